// File: doc/BRIEF.md
# Packed SIMD Shift-Left with Sticky Overflow

This block shifts a 32-bit operand left logically as independent packed lanes. A mode input picks the lane layout: two 16-bit halfword lanes, or four 8-bit byte lanes. The shifted word is produced combinationally on the same cycle as the operand. Bits pushed out of the top of a lane are dropped and never carry into the lane above. The block also holds a 32-bit control register.

Every lane is checked for overflow while an operation is valid. The test depends on the lane width:

- A byte lane overflows when any nonzero bit leaves the lane. This is an unsigned check.
- A halfword lane overflows when its signed value no longer fits after the shift.

If any lane overflows, bit 22 of the control register is set. The bit is sticky: it stays set until the register is written through its write port, which replaces the whole register.

The block is intended for a processor execute stage. The shifted result feeds the writeback path. The control register feeds the condition-reading logic.

Top module: `simd_shl_ovf`

## Requirements
- R1: While `rst_n` is low, the control register `ctl_q` is cleared to 0x00000000.
- R2: If the effective shift amount is zero, `res_data` equals `op_data` and no overflow is signalled.
- R3: In byte mode with effective shift s, a lane overflows exactly when its top s bits are not all zero.
- R4: In halfword mode with shift s, a lane overflows exactly when the lane, shifted right arithmetically by 15-s, is neither all zeros nor all ones.
- R5: Each lane of `res_data` is that lane of `op_data` shifted left by s, truncated to the lane width. No bit crosses a lane boundary.
- R6: `op_mode` = 0 selects halfword lanes [31:16] and [15:0]. `op_mode` = 1 selects byte lanes [31:24], [23:16], [15:8] and [7:0].
- R7: In byte mode only `op_shamt[2:0]` is used and bit 3 is ignored. In halfword mode all of `op_shamt[3:0]` is used.
- R8: A valid operation in which any lane overflows sets `ctl_q[22]` on the next clock edge. The bit then stays set until a write, and operations leave all other bits unchanged.
- R9: When `ctl_wr` is high, `ctl_q` loads `ctl_wdata` on the next edge. If an overflowing valid operation happens in the same cycle, bit 22 is then ORed to 1.
- R10: When `op_valid` is low and `ctl_wr` is low, `ctl_q` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe; overflow is recorded only while high |
| op_mode | input | 1 | Lane layout: 0 = two halfwords, 1 = four bytes |
| op_data | input | 32 | Packed operand |
| op_shamt | input | 4 | Shift amount (bit 3 ignored in byte mode) |
| ctl_wr | input | 1 | Control-register write enable |
| ctl_wdata | input | 32 | Control-register write data |
| res_data | output | 32 | Shifted packed result (combinational) |
| ctl_q | output | 32 | Control register; bit 22 is the sticky overflow flag |

## Verification
The assertions take for granted that `op_mode`, `op_shamt`, `op_valid` and `ctl_wr` are never unknown once reset is released. They also assume that the result port is judged only after the inputs have settled within a cycle. The stimulus meets both assumptions: every input is driven to a known value from time zero and changes only on the falling clock edge. Results are sampled a fraction of a cycle later, and the control register is sampled half a cycle after the rising edge that updates it. Each flag scenario first clears the register with a write, so every observed bit 22 comes from the operation under test alone.

// File: rtl/simd_shl_pkg.sv
package simd_shl_pkg;

    typedef enum logic {
        MODE_HALF = 1'b0,
        MODE_BYTE = 1'b1
    } shl_mode_e;

endpackage

// File: rtl/simd_shl_lane.sv
// One packed lane: left shift plus its overflow test.
module simd_shl_lane #(
    parameter int W          = 8,
    parameter bit SIGNED_CHK = 1'b0,
    localparam int SH_W      = $clog2(W)
) (
    input  logic [W-1:0]    lane_i,
    input  logic [SH_W-1:0] sh_i,
    output logic [W-1:0]    lane_o,
    output logic            ovf_o
);

    always_comb lane_o = lane_i << sh_i;

    generate
        if (SIGNED_CHK) begin : g_signed
            // Bits from the sign down to the new sign position must all agree.
            logic [SH_W-1:0]     rsh;
            logic signed [W-1:0] ext;
            always_comb begin
                rsh   = SH_W'(W - 1) - sh_i;
                ext   = $signed(lane_i) >>> rsh;
                ovf_o = (sh_i != '0) && (ext != '0) && (ext != '1);
            end
        end else begin : g_unsigned
            // Any set bit among the top sh_i positions is lost.
            logic [W-1:0] lost_mask;
            always_comb begin
                lost_mask = ~({W{1'b1}} >> sh_i);
                ovf_o     = |(lane_i & lost_mask);
            end
        end
    endgenerate

endmodule

// File: rtl/simd_shl_core.sv
// Lane arrays for both layouts, selected by mode.
module simd_shl_core
    import simd_shl_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int HALF_W  = 16,
    parameter int BYTE_W  = 8,
    localparam int SH_W   = $clog2(HALF_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [SH_W-1:0]   shamt_i,
    input  logic              mode_i,
    output logic [DATA_W-1:0] res_o,
    output logic              ovf_o
);

    localparam int N_HALF = DATA_W / HALF_W;
    localparam int N_BYTE = DATA_W / BYTE_W;
    localparam int BSH_W  = $clog2(BYTE_W);

    logic [DATA_W-1:0] half_res;
    logic [DATA_W-1:0] byte_res;
    logic [N_HALF-1:0] half_ovf;
    logic [N_BYTE-1:0] byte_ovf;

    generate
        for (genvar h = 0; h < N_HALF; h++) begin : g_half
            simd_shl_lane #(.W(HALF_W), .SIGNED_CHK(1'b1)) u_lane (
                .lane_i (data_i[h*HALF_W +: HALF_W]),
                .sh_i   (shamt_i),
                .lane_o (half_res[h*HALF_W +: HALF_W]),
                .ovf_o  (half_ovf[h])
            );
        end
        for (genvar b = 0; b < N_BYTE; b++) begin : g_byte
            simd_shl_lane #(.W(BYTE_W), .SIGNED_CHK(1'b0)) u_lane (
                .lane_i (data_i[b*BYTE_W +: BYTE_W]),
                .sh_i   (shamt_i[BSH_W-1:0]),
                .lane_o (byte_res[b*BYTE_W +: BYTE_W]),
                .ovf_o  (byte_ovf[b])
            );
        end
    endgenerate

    always_comb begin
        if (shl_mode_e'(mode_i) == MODE_BYTE) begin
            res_o = byte_res;
            ovf_o = |byte_ovf;
        end else begin
            res_o = half_res;
            ovf_o = |half_ovf;
        end
    end

endmodule

// File: rtl/simd_shl_ctl.sv
// Control register with sticky overflow bit.
module simd_shl_ctl #(
    parameter int DATA_W   = 32,
    parameter int FLAG_BIT = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              set_i,
    output logic [DATA_W-1:0] ctl_o
);

    typedef struct packed {
        logic [DATA_W-1:0] reg_val;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.reg_val = wdata_i;
        end
        if (set_i) begin
            st_d.reg_val[FLAG_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_o = st_q.reg_val;

endmodule

// File: rtl/simd_shl_ovf.sv
module simd_shl_ovf #(
    parameter int DATA_W   = 32,
    parameter int HALF_W   = 16,
    parameter int BYTE_W   = 8,
    parameter int FLAG_BIT = 22,
    localparam int SH_W    = $clog2(HALF_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_mode,
    input  logic [DATA_W-1:0] op_data,
    input  logic [SH_W-1:0]   op_shamt,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_wdata,
    output logic [DATA_W-1:0] res_data,
    output logic [DATA_W-1:0] ctl_q
);

    logic any_ovf;

    simd_shl_core #(
        .DATA_W (DATA_W),
        .HALF_W (HALF_W),
        .BYTE_W (BYTE_W)
    ) u_core (
        .data_i  (op_data),
        .shamt_i (op_shamt),
        .mode_i  (op_mode),
        .res_o   (res_data),
        .ovf_o   (any_ovf)
    );

    simd_shl_ctl #(
        .DATA_W   (DATA_W),
        .FLAG_BIT (FLAG_BIT)
    ) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctl_wr),
        .wdata_i (ctl_wdata),
        .set_i   (op_valid && any_ovf),
        .ctl_o   (ctl_q)
    );

endmodule

// File: rtl/simd_shl_ovf_chk.sv
module simd_shl_ovf_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic        op_mode,
    input logic [31:0] op_data,
    input logic [3:0]  op_shamt,
    input logic        ctl_wr,
    input logic [31:0] ctl_wdata,
    input logic [31:0] res_data,
    input logic [31:0] ctl_q
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (ctl_q == 32'h0));

    p_zero_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode ? (op_shamt[2:0] == 3'd0) : (op_shamt == 4'd0)) |-> (res_data == op_data));

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr && ctl_q[22]) |=> ctl_q[22]);

    p_other_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> (ctl_q[31:23] == $past(ctl_q[31:23])) && (ctl_q[21:0] == $past(ctl_q[21:0])));

    p_write_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (ctl_q[31:23] == $past(ctl_wdata[31:23])) && (ctl_q[21:0] == $past(ctl_wdata[21:0])));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr && !op_valid) |=> $stable(ctl_q));

endmodule

bind simd_shl_ovf simd_shl_ovf_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_mode   (op_mode),
    .op_data   (op_data),
    .op_shamt  (op_shamt),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .res_data  (res_data),
    .ctl_q     (ctl_q)
);

// File: tb/simd_shl_ovf_tb.sv
`timescale 1ns/1ps
module simd_shl_ovf_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_mode = 1'b0;
    logic [31:0] op_data = '0;
    logic [3:0]  op_shamt = '0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] res_data;
    logic [31:0] ctl_q;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    localparam bit HALF = 1'b0;
    localparam bit BYTE = 1'b1;

    always #2 clk = ~clk;

    simd_shl_ovf u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_mode   (op_mode),
        .op_data   (op_data),
        .op_shamt  (op_shamt),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .res_data  (res_data),
        .ctl_q     (ctl_q)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic write_ctl(input logic [31:0] val);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = val;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    // Clears the register, applies one operation, checks result and flag.
    task automatic run_op(input bit mode, input logic [31:0] data, input logic [3:0] sh,
                          input logic [31:0] exp_res, input bit exp_flag, input string req);
        write_ctl(32'h0);
        op_valid = 1'b1; op_mode = mode; op_data = data; op_shamt = sh;
        #1;
        check(res_data === exp_res, req, res_data, exp_res);
        @(negedge clk);
        op_valid = 1'b0;
        check(ctl_q[22] === exp_flag, req, {31'b0, ctl_q[22]}, {31'b0, exp_flag});
    endtask

    task automatic t_reset;
        check(ctl_q === 32'h0, "R1", ctl_q, 32'h0);
    endtask

    task automatic t_zero_shift;
        run_op(HALF, 32'h8000FFFF, 4'd0, 32'h8000FFFF, 1'b0, "R2");
        run_op(BYTE, 32'hFF8001AB, 4'd0, 32'hFF8001AB, 1'b0, "R2");
    endtask

    task automatic t_halfword;
        run_op(HALF, 32'h7FFF8000, 4'd1, 32'hFFFE0000, 1'b1, "R4");
        run_op(HALF, 32'h00000001, 4'd15, 32'h00008000, 1'b1, "R4");
        run_op(HALF, 32'hFFFF0001, 4'd3, 32'hFFF80008, 1'b0, "R4");
        run_op(HALF, 32'hFFFF0000, 4'd15, 32'h80000000, 1'b0, "R4");
    endtask

    task automatic t_byte;
        run_op(BYTE, 32'h00000001, 4'd7, 32'h00000080, 1'b0, "R3");
        run_op(BYTE, 32'h87654321, 4'd3, 32'h38281808, 1'b1, "R3");
    endtask

    task automatic t_lanes;
        run_op(BYTE, 32'h80808080, 4'd1, 32'h00000000, 1'b1, "R5");
        run_op(HALF, 32'h00FF00FF, 4'd4, 32'h0FF00FF0, 1'b0, "R5_R6");
        run_op(BYTE, 32'h00FF00FF, 4'd4, 32'h00F000F0, 1'b1, "R6");
    endtask

    task automatic t_shamt_bits;
        run_op(BYTE, 32'h01020304, 4'd9, 32'h02040608, 1'b0, "R7");
        run_op(BYTE, 32'hC0A01234, 4'd8, 32'hC0A01234, 1'b0, "R7");
        run_op(HALF, 32'h01020304, 4'd9, 32'h04000800, 1'b1, "R7");
    endtask

    task automatic t_sticky;
        run_op(BYTE, 32'h80000000, 4'd1, 32'h00000000, 1'b1, "R8");
        // Clean operation afterwards must keep the flag.
        op_valid = 1'b1; op_mode = BYTE; op_data = 32'h01010101; op_shamt = 4'd1;
        @(negedge clk);
        op_valid = 1'b0;
        check(ctl_q === 32'h00400000, "R8", ctl_q, 32'h00400000);
        // Operation with other bits preset: only bit 22 changes.
        write_ctl(32'h12345678);
        check(ctl_q === 32'h12345678, "R9", ctl_q, 32'h12345678);
        op_valid = 1'b1; op_mode = HALF; op_data = 32'h40000000; op_shamt = 4'd2;
        @(negedge clk);
        op_valid = 1'b0;
        check(ctl_q === 32'h12745678, "R8", ctl_q, 32'h12745678);
    endtask

    task automatic t_write_collide;
        write_ctl(32'hFFFFFFFF);
        op_valid = 1'b1; op_mode = BYTE; op_data = 32'hFF000000; op_shamt = 4'd4;
        ctl_wr = 1'b1; ctl_wdata = 32'h00000005;
        @(negedge clk);
        op_valid = 1'b0; ctl_wr = 1'b0;
        check(ctl_q === 32'h00400005, "R9", ctl_q, 32'h00400005);
        write_ctl(32'h00000000);
        check(ctl_q === 32'h00000000, "R9", ctl_q, 32'h00000000);
    endtask

    task automatic t_invalid;
        write_ctl(32'h0000A000);
        op_valid = 1'b0; op_mode = BYTE; op_data = 32'hFFFFFFFF; op_shamt = 4'd7;
        @(negedge clk);
        @(negedge clk);
        check(ctl_q === 32'h0000A000, "R10", ctl_q, 32'h0000A000);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_zero_shift();
        t_halfword();
        t_byte();
        t_lanes();
        t_shamt_bits();
        t_sticky();
        t_write_collide();
        t_invalid();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule